// File: doc/BRIEF.md
# Buffered Asynchronous Serial Transmitter with Clear-to-Send Gating

This block sends characters on an asynchronous serial line. It has two storage stages. A host writes a character into a holding buffer. When the line is free and the start conditions are met, the block copies that character into a shift stage and sends it as a framed bit stream. The host can then write the next character into the buffer while the current frame is still going out.

At run time the host selects the character length (7, 8 or 9 bits), the parity (none, odd or even) and the stop-bit count (1 or 2). Each bit lasts 16 oversampling ticks. The tick rate comes from a divisor fed by one of three prescaled versions of the system clock, or by an external tick enable. An optional clear-to-send input, active low, holds back the start of a new frame. A single interrupt pulse marks one of two moments, chosen by the host: the moment the buffer is handed to the shifter, or the end of the frame's last stop bit.

Top module: `uart_tx_flow`

## Requirements
- R1: While reset is held, and just after it, `tx_out` is 1, `buf_empty` is 1 and `irq` is 0.
- R2: A frame on `tx_out` is one low start bit, then the data bits least significant bit first, then the optional parity bit, then the stop bits, which are high. Between frames the line stays high.
- R3: `char_len` selects the data length: 0 gives 7 bits, 1 gives 8 bits, 2 or 3 gives 9 bits. Buffer bits above the selected length are not sent. The ninth bit comes directly before the parity bit, or directly before the stop bits when parity is off.
- R4: `parity_mode` 1 adds an odd-parity bit and 2 adds an even-parity bit, so that the total number of ones over the data and parity bits is odd or even. Values 0 and 3 send no parity bit.
- R5: `two_stop` = 0 sends one stop bit and `two_stop` = 1 sends two.
- R6: Every bit lasts 16×(`divisor`+1) source ticks. `clk_sel` 0, 1 and 2 give a source tick every 1, 8 and 32 clocks, counted from the frame's start. `clk_sel` 3 uses `ext_tick` as the source tick.
- R7: `buf_empty` goes to 1 on the clock edge that moves the buffer into the shifter, and goes to 0 on an edge where `wr_en` is high. A character written while a frame is being sent waits in the buffer until that frame has ended.
- R8: A frame starts on a clock edge only when the block is idle, the buffer holds data, `tx_en` is 1, and either `cts_en` is 0 or `cts_n` is 0.
- R9: `cts_n` is looked at only when a frame is about to start. A frame that has already started runs to its end whatever `cts_n` does.
- R10: `irq` is a pulse one clock long. With `irq_sel` = 0 it comes on the edge where the buffer is handed to the shifter. With `irq_sel` = 1 it comes on the edge where the last stop bit ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clk_sel | input | 2 | Tick source: system clock divided by 1, 8 or 32, or the external tick |
| ext_tick | input | 1 | External tick enable, used when `clk_sel` is 3 |
| divisor | input | 8 | Rate divisor n; each bit lasts 16×(n+1) source ticks |
| char_len | input | 2 | Data length: 7, 8 or 9 bits |
| parity_mode | input | 2 | Parity: none, odd or even |
| two_stop | input | 1 | Selects two stop bits instead of one |
| tx_en | input | 1 | Transmit enable |
| cts_en | input | 1 | Enables clear-to-send gating |
| cts_n | input | 1 | Clear-to-send, active low |
| irq_sel | input | 1 | Interrupt moment: 0 at handoff, 1 at end of frame |
| wr_en | input | 1 | Writes `wr_data` into the buffer |
| wr_data | input | 9 | Character to be sent |
| buf_empty | output | 1 | The buffer holds no character |
| tx_out | output | 1 | Serial line output |
| irq | output | 1 | Interrupt pulse |

## Verification
The bench attacks each frame-shape corner: 7-bit characters with extra high bits set, 9-bit characters where the ninth bit has to come before the parity bit, both parity senses, and two stop bits. A shifter built with a wrong bit index would send stray bits, drop a bit or put parity in the wrong place, and the line would stop matching the reference. The bench also writes a second character while a frame is going out, which catches a block that sends too early or loses the buffered character. It holds back the start with `tx_en` low and with `cts_n` high, then raises `cts_n` in the middle of a frame; a design that samples clear-to-send at the wrong time would either start a frame it should not or cut a frame short. Finally, it measures the start-bit width for every internal prescaler, and it checks the interrupt at both selectable moments, where an off-by-one edge shows up as a pulse on the wrong cycle.

// File: rtl/uart_tx_flow.sv
module uart_tx_flow #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       clk_sel,
  input  logic             ext_tick,
  input  logic [DIV_W-1:0] divisor,
  input  logic [1:0]       char_len,
  input  logic [1:0]       parity_mode,
  input  logic             two_stop,
  input  logic             tx_en,
  input  logic             cts_en,
  input  logic             cts_n,
  input  logic             irq_sel,
  input  logic             wr_en,
  input  logic [8:0]       wr_data,
  output logic             buf_empty,
  output logic             tx_out,
  output logic             irq
);
  localparam int FRAME_W = 13;
  localparam int CNT_W   = $clog2(FRAME_W + 1);

  logic [8:0]         buf_q;
  logic               busy;
  logic [FRAME_W-1:0] sh, ld;
  logic [CNT_W-1:0]   nbits, bit_cnt, ld_n;
  logic [4:0]         pre_cnt, pre_lim;
  logic [DIV_W-1:0]   div_cnt;
  logic [3:0]         os_cnt;
  logic               src_tick, os_tick, bit_done, last_bit, start, par_en, pbit;
  int                 len;

  assign len      = (char_len == 2'd0) ? 7 : (char_len == 2'd1) ? 8 : 9;
  assign par_en   = (parity_mode == 2'd1) || (parity_mode == 2'd2);
  assign pre_lim  = (clk_sel == 2'd1) ? 5'd7 : (clk_sel == 2'd2) ? 5'd31 : 5'd0;
  assign src_tick = (clk_sel == 2'd3) ? ext_tick : (pre_cnt == pre_lim);
  assign os_tick  = src_tick && (div_cnt == divisor);
  assign bit_done = os_tick && (os_cnt == 4'd15);
  assign last_bit = bit_done && (bit_cnt == nbits - CNT_W'(1));
  assign start    = !busy && !buf_empty && tx_en && (!cts_en || !cts_n);
  assign tx_out   = busy ? sh[0] : 1'b1;

  always_comb begin
    logic [8:0] d;
    d = buf_q;
    if (char_len == 2'd0) d[8:7] = 2'b00;
    else if (char_len == 2'd1) d[8] = 1'b0;
    pbit = (parity_mode == 2'd1) ? ~^d : ^d;
    ld = '1;
    ld[0] = 1'b0;
    for (int i = 0; i < 9; i++)
      if (i < len) ld[i+1] = d[i];
    if (par_en) ld[len+1] = pbit;
    ld_n = CNT_W'(len + 2 + (par_en ? 1 : 0) + (two_stop ? 1 : 0));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q     <= '0;
      buf_empty <= 1'b1;
      busy      <= 1'b0;
      sh        <= '1;
      nbits     <= '0;
      bit_cnt   <= '0;
      pre_cnt   <= '0;
      div_cnt   <= '0;
      os_cnt    <= '0;
      irq       <= 1'b0;
    end else begin
      irq <= 1'b0;
      if (start) begin
        sh        <= ld;
        nbits     <= ld_n;
        bit_cnt   <= '0;
        pre_cnt   <= '0;
        div_cnt   <= '0;
        os_cnt    <= '0;
        busy      <= 1'b1;
        buf_empty <= 1'b1;
        irq       <= !irq_sel;
      end else if (busy) begin
        pre_cnt <= src_tick ? 5'd0 : pre_cnt + 5'd1;
        if (src_tick) div_cnt <= (div_cnt == divisor) ? '0 : div_cnt + DIV_W'(1);
        if (os_tick) os_cnt <= os_cnt + 4'd1;
        if (bit_done) begin
          sh      <= {1'b1, sh[FRAME_W-1:1]};
          bit_cnt <= bit_cnt + CNT_W'(1);
        end
        if (last_bit) begin
          busy <= 1'b0;
          irq  <= irq_sel;
        end
      end
      if (wr_en) begin
        buf_q     <= wr_data;
        buf_empty <= 1'b0;
      end
    end
  end

  assert_start_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !tx_out);
  assert_bit_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (bit_cnt < nbits));
  assert_last_stop_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(tx_out));
  assert_handoff_empties_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(busy) && !$past(wr_en)) |-> buf_empty);
  assert_start_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($past(tx_en) && (!$past(cts_en) || !$past(cts_n))));
  assert_irq_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);
endmodule

// File: tb/uart_tx_flow_bench.sv
module uart_tx_flow_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] clk_sel = 2'd0;
  logic       ext_tick = 1'b0;
  logic [7:0] divisor = 8'd0;
  logic [1:0] char_len = 2'd1;
  logic [1:0] parity_mode = 2'd0;
  logic       two_stop = 1'b0;
  logic       tx_en = 1'b1;
  logic       cts_en = 1'b0;
  logic       cts_n = 1'b1;
  logic       irq_sel = 1'b0;
  logic       wr_en = 1'b0;
  logic [8:0] wr_data = '0;
  logic       buf_empty, tx_out, irq;

  always #10 clk = ~clk;

  uart_tx_flow u_uart_tx_flow (
    .clk(clk), .rst_n(rst_n), .clk_sel(clk_sel), .ext_tick(ext_tick),
    .divisor(divisor), .char_len(char_len), .parity_mode(parity_mode),
    .two_stop(two_stop), .tx_en(tx_en), .cts_en(cts_en), .cts_n(cts_n),
    .irq_sel(irq_sel), .wr_en(wr_en), .wr_data(wr_data),
    .buf_empty(buf_empty), .tx_out(tx_out), .irq(irq)
  );

  int    checks = 0, errors = 0, cycles = 0, ext_cnt = 0;
  string cur_req = "R2";

  bit       m_busy = 0, m_empty = 1, m_irq = 0, tick;
  bit [8:0] m_buf = 0;
  bit       q[$];
  int       m_cyc = 0, m_t = 0;

  function automatic int period(input logic [1:0] s);
    return (s == 2'd1) ? 8 : (s == 2'd2) ? 32 : 1;
  endfunction

  task automatic build_frame();
    int n, ones;
    n = (char_len == 2'd0) ? 7 : (char_len == 2'd1) ? 8 : 9;
    ones = 0;
    q.delete();
    q.push_back(1'b0);
    for (int i = 0; i < n; i++) begin
      q.push_back(m_buf[i]);
      ones += m_buf[i];
    end
    if (parity_mode == 2'd1) q.push_back((ones % 2) == 0);
    if (parity_mode == 2'd2) q.push_back((ones % 2) == 1);
    q.push_back(1'b1);
    if (two_stop) q.push_back(1'b1);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      m_busy = 0; m_empty = 1; m_irq = 0; q.delete();
    end else begin
      m_irq = 0;
      if (m_busy) begin
        m_cyc++;
        tick = (clk_sel == 2'd3) ? ext_tick : ((m_cyc % period(clk_sel)) == 0);
        if (tick) begin
          m_t++;
          if (m_t == 16 * (divisor + 1)) begin
            m_t = 0;
            void'(q.pop_front());
            if (q.size() == 0) begin
              m_busy = 0;
              m_irq = irq_sel;
            end
          end
        end
      end else if (!m_empty && tx_en && (!cts_en || !cts_n)) begin
        build_frame();
        m_busy = 1; m_empty = 1; m_cyc = 0; m_t = 0; m_irq = !irq_sel;
      end
      if (wr_en) begin
        m_buf = wr_data;
        m_empty = 0;
      end
    end
  end

  task automatic check(input logic act, input logic exp, input string req, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s at cycle %0d: actual %b expected %b", req, what, cycles, act, exp);
    end
  endtask

  always @(negedge clk) begin
    ext_cnt++;
    ext_tick <= (ext_cnt % 3) == 0;
    if (rst_n) begin
      check(tx_out, m_busy ? q[0] : 1'b1, cur_req, "tx_out");
      check(buf_empty, m_empty, "R7", "buf_empty");
      check(irq, m_irq, "R10", "irq");
    end
  end

  always @(posedge clk) begin
    if (cycles > 150000) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic cfg(input logic [1:0] len, input logic [1:0] par, input logic two,
                     input logic [1:0] sel, input logic [7:0] dv, input logic isel);
    @(negedge clk);
    char_len = len; parity_mode = par; two_stop = two;
    clk_sel = sel; divisor = dv; irq_sel = isel;
  endtask

  task automatic send(input logic [8:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_done();
    do @(negedge clk); while (m_busy || !m_empty);
    repeat (3) @(negedge clk);
  endtask

  task automatic measure_start(input int exp, input string req);
    int w;
    w = 0;
    send(9'h0FF);
    while (tx_out) @(negedge clk);
    while (!tx_out) begin
      w++;
      @(negedge clk);
    end
    checks++;
    if (w != exp) begin
      errors++;
      $display("FAIL %s start bit width actual %0d expected %0d", req, w, exp);
    end
    wait_done();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(tx_out, 1'b1, "R1", "tx_out in reset");
    check(buf_empty, 1'b1, "R1", "buf_empty in reset");
    check(irq, 1'b0, "R1", "irq in reset");
    rst_n = 1'b1;
    @(negedge clk);
    check(tx_out, 1'b1, "R1", "tx_out after reset");
    check(buf_empty, 1'b1, "R1", "buf_empty after reset");

    cur_req = "R2";
    cfg(2'd1, 2'd0, 1'b0, 2'd0, 8'd0, 1'b0);
    send(9'h0A5); wait_done();
    send(9'h03C); wait_done();

    cur_req = "R3";
    cfg(2'd0, 2'd2, 1'b1, 2'd0, 8'd0, 1'b1);
    send(9'h1FF); wait_done();
    cfg(2'd2, 2'd1, 1'b0, 2'd0, 8'd0, 1'b0);
    send(9'h155); wait_done();
    send(9'h100); wait_done();

    cur_req = "R4";
    cfg(2'd1, 2'd1, 1'b0, 2'd0, 8'd0, 1'b1);
    send(9'h081); wait_done();
    cfg(2'd1, 2'd2, 1'b0, 2'd0, 8'd0, 1'b1);
    send(9'h007); wait_done();
    cfg(2'd1, 2'd3, 1'b0, 2'd0, 8'd0, 1'b0);
    send(9'h0F0); wait_done();

    cur_req = "R5";
    cfg(2'd2, 2'd0, 1'b1, 2'd0, 8'd0, 1'b1);
    send(9'h1AA); wait_done();

    cur_req = "R7";
    cfg(2'd1, 2'd0, 1'b0, 2'd0, 8'd0, 1'b0);
    send(9'h011);
    repeat (20) @(negedge clk);
    send(9'h0EE);
    repeat (40) @(negedge clk);
    check(buf_empty, 1'b0, "R7", "second character held during frame");
    wait_done();

    cur_req = "R8";
    tx_en = 1'b0;
    send(9'h05A);
    repeat (100) @(negedge clk);
    check(tx_out, 1'b1, "R8", "no start while tx_en low");
    check(buf_empty, 1'b0, "R8", "buffer kept while tx_en low");
    tx_en = 1'b1;
    wait_done();
    cts_en = 1'b1; cts_n = 1'b1;
    send(9'h0C3);
    repeat (100) @(negedge clk);
    check(tx_out, 1'b1, "R8", "no start while cts_n high");

    cur_req = "R9";
    cts_n = 1'b0;
    repeat (40) @(negedge clk);
    cts_n = 1'b1;
    wait_done();
    check(tx_out, 1'b1, "R9", "line idle after completed frame");
    cts_en = 1'b0;

    cur_req = "R6";
    cfg(2'd1, 2'd0, 1'b0, 2'd0, 8'd2, 1'b0);
    measure_start(48, "R6");
    cfg(2'd1, 2'd0, 1'b0, 2'd1, 8'd1, 1'b0);
    measure_start(256, "R6");
    cfg(2'd1, 2'd0, 1'b0, 2'd2, 8'd0, 1'b0);
    measure_start(512, "R6");
    cfg(2'd1, 2'd2, 1'b0, 2'd3, 8'd0, 1'b1);
    send(9'h0B4); wait_done();

    cur_req = "R10";
    cfg(2'd1, 2'd1, 1'b1, 2'd0, 8'd0, 1'b1);
    send(9'h066); wait_done();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule